// File: doc/BRIEF.md
# Dual-clock posted-write interval timer

This block is a 32-bit up-counting timer. A bus domain reaches it through simple write and read strobes, and the count itself runs on a slower functional clock. A bus write completes in a single bus cycle. The value is held in a per-register posting channel and moved into the timer domain in the background by a toggle handshake. Software can see which writes are still in flight in a pending-status register, with one bit per writable register. Software is expected to wait for that bit to drop before it writes the same register again. If it does not wait, a value that has not yet been launched is replaced by the newer one and is never applied.

The counter increments once per timer clock while it runs. When it steps past the all-ones value it raises an overflow event. The counter then either reloads from the load register (auto-reload) or returns to zero and halts. Overflow events set a sticky flag in the bus domain, which drives an interrupt output and is cleared by writing one. Count reads come from a snapshot that a second toggle handshake refreshes continuously, so a read never returns a half-updated value. One asynchronous reset input is released separately into each domain through its own synchronizer.

The posting channel is a state machine with states IDLE (nothing in flight), SEND (one value crossing) and SEND_Q (one value crossing and a newer one parked). A write in IDLE launches and moves to SEND. A write in SEND parks the value and moves to SEND_Q. A returned acknowledge in SEND moves to IDLE, or launches the newer value at once if a write arrives in that same cycle. A write in SEND_Q overwrites the parked value, which discards the older one. A returned acknowledge in SEND_Q launches the parked value, or the incoming one if a write coincides, and moves to SEND. The timer core has two states, HALT and RUN. RUN is entered by applying a control value with the start bit set. RUN returns to HALT when a control value with start clear is applied, or on an overflow without auto-reload.

Top module: `posted_timer`

## Requirements
- R1: After reset, reads of every address (0 control, 1 load, 2 count, 3 pending, 4 flag) return zero and `ovf_irq` is low.
- R2: A write to control (address 0), load (address 1) or count (address 2) sets its pending bit (bit 0, 1 or 2 of address 3) in time for a read issued in the next bus cycle. The bit clears by itself once the value has been applied in the timer domain.
- R3: When several writes hit one register while it is pending, the register ends up holding the last value written. A value that was parked and then overwritten is never applied.
- R4: A value written to the count register, applied while halted, is returned by reads of address 2. Writing the count does not change the load value that address 1 reads back.
- R5: While running, the count rises by exactly one per timer clock.
- R6: A running counter holding 0xFFFFFFFF overflows on the next timer tick. Starting from 0xFFFFFFFF−N, the overflow therefore comes on tick N+1 and never earlier. An overflow sets the flag (address 4, bit 0) and `ovf_irq`.
- R7: On overflow with the auto-reload bit (control bit 1) clear, the count becomes zero and the counter halts. After that the start bit (control bit 0) reads back as 0.
- R8: On overflow with auto-reload set, the count reloads from the load register and counting continues.
- R9: Writing 1 to flag bit 0 clears the flag and `ovf_irq`. Writing 0 leaves them unchanged. An overflow in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_n | input | 1 | Asynchronous active-low reset, released per domain |
| bus_clk | input | 1 | Register-interface clock |
| tmr_clk | input | 1 | Functional timer clock (slower than bus_clk) |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| rd_en | input | 1 | Read strobe; data appears on rdata after the next bus edge |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ovf_irq | output | 1 | Sticky overflow flag |

## Verification
The assertions take three things for granted. Addresses are only those listed above. The timer clock is at most half the bus clock, so each toggle survives a two-flop sampler. A held-data word in a posting channel does not change between its launch and its acknowledge. The stimulus respects all three. It drives strobes and data only at falling bus edges and runs the timer at 14 ns against a 4 ns bus clock. It relies on the channel state machine, and not on software, for data stability. Both the in-order path (polling the pending bit before every write) and the careless path (back-to-back writes) are exercised, so the assertions on pending, wrap and halt behaviour meet both.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_LOAD  = 3'd1;
    localparam logic [2:0] ADR_COUNT = 3'd2;
    localparam logic [2:0] ADR_PEND  = 3'd3;
    localparam logic [2:0] ADR_FLAG  = 3'd4;

    localparam int CH_CTRL  = 0;
    localparam int CH_LOAD  = 1;
    localparam int CH_COUNT = 2;
    localparam int NUM_CH   = 3;

    localparam int CTRL_START = 0;
    localparam int CTRL_AUTO  = 1;
    localparam int CTRL_W     = 2;

    typedef enum logic [1:0] {
        PC_IDLE   = 2'd0,
        PC_SEND   = 2'd1,
        PC_SEND_Q = 2'd2
    } pchan_state_e;

    typedef enum logic {
        TC_HALT = 1'b0,
        TC_RUN  = 1'b1
    } tcore_state_e;
endpackage

// File: rtl/pt_rst_sync.sv
module pt_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n = shift_q[STAGES-1];
endmodule

// File: rtl/pt_post_chan.sv
module pt_post_chan
    import pt_pkg::*;
#(
    parameter int W    = 32,
    parameter int SYNC = 2
) (
    input  logic         bus_clk,
    input  logic         bus_rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         pending,
    input  logic         tmr_clk,
    input  logic         tmr_rst_n,
    output logic         apply,
    output logic [W-1:0] apply_data
);
    pchan_state_e   st_q, st_nx;
    logic [W-1:0]   hold_q, park_q;
    logic           req_q;
    logic [SYNC-1:0] ack_sync_q;
    logic           ack_tgl_q;
    logic [SYNC-1:0] req_sync_q;
    logic           done;
    logic           launch_new, launch_park, do_park;

    assign done = (st_q != PC_IDLE) && (ack_sync_q[SYNC-1] == req_q);

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            st_q <= PC_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    always_comb begin
        st_nx       = st_q;
        launch_new  = 1'b0;
        launch_park = 1'b0;
        do_park     = 1'b0;
        unique case (st_q)
            PC_IDLE: begin
                if (wr) begin
                    st_nx      = PC_SEND;
                    launch_new = 1'b1;
                end
            end
            PC_SEND: begin
                if (done && wr) begin
                    launch_new = 1'b1;
                end else if (done) begin
                    st_nx = PC_IDLE;
                end else if (wr) begin
                    st_nx   = PC_SEND_Q;
                    do_park = 1'b1;
                end
            end
            PC_SEND_Q: begin
                if (done && wr) begin
                    st_nx      = PC_SEND;
                    launch_new = 1'b1;
                end else if (done) begin
                    st_nx       = PC_SEND;
                    launch_park = 1'b1;
                end else if (wr) begin
                    do_park = 1'b1;
                end
            end
            default: st_nx = PC_IDLE;
        endcase
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            hold_q <= '0;
            park_q <= '0;
            req_q  <= 1'b0;
        end else begin
            if (launch_new) begin
                hold_q <= wdata;
                req_q  <= ~req_q;
            end else if (launch_park) begin
                hold_q <= park_q;
                req_q  <= ~req_q;
            end
            if (do_park) begin
                park_q <= wdata;
            end
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            ack_sync_q <= '0;
        end else begin
            ack_sync_q <= {ack_sync_q[SYNC-2:0], ack_tgl_q};
        end
    end

    assign pending = (st_q != PC_IDLE);

    always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
        if (!tmr_rst_n) begin
            req_sync_q <= '0;
            ack_tgl_q  <= 1'b0;
        end else begin
            req_sync_q <= {req_sync_q[SYNC-2:0], req_q};
            ack_tgl_q  <= req_sync_q[SYNC-1];
        end
    end

    assign apply      = req_sync_q[SYNC-1] ^ ack_tgl_q;
    assign apply_data = hold_q;
endmodule

// File: rtl/pt_snapshot.sv
module pt_snapshot #(
    parameter int W    = 33,
    parameter int SYNC = 2
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_value,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_value
);
    logic [W-1:0]    snap_q;
    logic            tgl_q;
    logic [SYNC-1:0] back_sync_q;
    logic [SYNC-1:0] fwd_sync_q;
    logic            seen_q;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            snap_q      <= '0;
            tgl_q       <= 1'b0;
            back_sync_q <= '0;
        end else begin
            back_sync_q <= {back_sync_q[SYNC-2:0], seen_q};
            if (back_sync_q[SYNC-1] == tgl_q) begin
                snap_q <= src_value;
                tgl_q  <= ~tgl_q;
            end
        end
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            fwd_sync_q <= '0;
            seen_q     <= 1'b0;
            dst_value  <= '0;
        end else begin
            fwd_sync_q <= {fwd_sync_q[SYNC-2:0], tgl_q};
            if (fwd_sync_q[SYNC-1] != seen_q) begin
                dst_value <= snap_q;
                seen_q    <= fwd_sync_q[SYNC-1];
            end
        end
    end
endmodule

// File: rtl/pt_counter.sv
module pt_counter
    import pt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_apply,
    input  logic [CTRL_W-1:0] ctrl_data,
    input  logic              load_apply,
    input  logic [DW-1:0]     load_data,
    input  logic              cnt_apply,
    input  logic [DW-1:0]     cnt_data,
    output logic [DW-1:0]     count,
    output logic [DW-1:0]     load_val,
    output logic              auto_on,
    output logic              running,
    output logic              ovf_evt,
    output logic              ovf_tgl
);
    tcore_state_e st_q, st_nx;
    logic         at_top;

    assign at_top  = (count == '1);
    assign running = (st_q == TC_RUN);
    assign ovf_evt = running && at_top && !cnt_apply;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TC_HALT;
        end else begin
            st_q <= st_nx;
        end
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            TC_HALT: begin
                if (ctrl_apply && ctrl_data[CTRL_START]) begin
                    st_nx = TC_RUN;
                end
            end
            TC_RUN: begin
                if (ctrl_apply) begin
                    st_nx = ctrl_data[CTRL_START] ? TC_RUN : TC_HALT;
                end else if (ovf_evt && !auto_on) begin
                    st_nx = TC_HALT;
                end
            end
            default: st_nx = TC_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            load_val <= '0;
            auto_on  <= 1'b0;
            ovf_tgl  <= 1'b0;
        end else begin
            if (cnt_apply) begin
                count <= cnt_data;
            end else if (running) begin
                if (at_top) begin
                    count <= auto_on ? load_val : '0;
                end else begin
                    count <= count + 1'b1;
                end
            end
            if (load_apply) begin
                load_val <= load_data;
            end
            if (ctrl_apply) begin
                auto_on <= ctrl_data[CTRL_AUTO];
            end
            if (ovf_evt) begin
                ovf_tgl <= ~ovf_tgl;
            end
        end
    end
endmodule

// File: rtl/posted_timer.sv
module posted_timer
    import pt_pkg::*;
#(
    parameter int DW   = 32,
    parameter int SYNC = 2
) (
    input  logic          arst_n,
    input  logic          bus_clk,
    input  logic          tmr_clk,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ovf_irq
);
    localparam int SNAP_W = DW + 1;

    logic              b_rst_n, t_rst_n;
    logic [NUM_CH-1:0] ch_wr, pend_vec, ch_apply;
    logic [DW-1:0]     ch_data [NUM_CH];
    logic [DW-1:0]     cnt_q, load_q;
    logic              auto_q, run_q, ovf_evt, ovf_tgl;
    logic [SNAP_W-1:0] snap_b;
    logic              auto_shadow_q;
    logic [DW-1:0]     load_shadow_q;
    logic [SYNC-1:0]   ev_sync_q;
    logic              ev_seen_q, flag_set, flag_clr, ovf_flag_q;

    pt_rst_sync #(.STAGES(SYNC)) u_bus_rst (
        .clk(bus_clk), .arst_n(arst_n), .rst_n(b_rst_n)
    );
    pt_rst_sync #(.STAGES(SYNC)) u_tmr_rst (
        .clk(tmr_clk), .arst_n(arst_n), .rst_n(t_rst_n)
    );

    assign ch_wr[CH_CTRL]  = wr_en && (addr == ADR_CTRL);
    assign ch_wr[CH_LOAD]  = wr_en && (addr == ADR_LOAD);
    assign ch_wr[CH_COUNT] = wr_en && (addr == ADR_COUNT);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam int CW = (c == CH_CTRL) ? CTRL_W : DW;
        logic [CW-1:0] ad;
        pt_post_chan #(.W(CW), .SYNC(SYNC)) u_chan (
            .bus_clk   (bus_clk),
            .bus_rst_n (b_rst_n),
            .wr        (ch_wr[c]),
            .wdata     (wdata[CW-1:0]),
            .pending   (pend_vec[c]),
            .tmr_clk   (tmr_clk),
            .tmr_rst_n (t_rst_n),
            .apply     (ch_apply[c]),
            .apply_data(ad)
        );
        assign ch_data[c] = DW'(ad);
    end

    pt_counter #(.DW(DW)) u_core (
        .clk       (tmr_clk),
        .rst_n     (t_rst_n),
        .ctrl_apply(ch_apply[CH_CTRL]),
        .ctrl_data (ch_data[CH_CTRL][CTRL_W-1:0]),
        .load_apply(ch_apply[CH_LOAD]),
        .load_data (ch_data[CH_LOAD]),
        .cnt_apply (ch_apply[CH_COUNT]),
        .cnt_data  (ch_data[CH_COUNT]),
        .count     (cnt_q),
        .load_val  (load_q),
        .auto_on   (auto_q),
        .running   (run_q),
        .ovf_evt   (ovf_evt),
        .ovf_tgl   (ovf_tgl)
    );

    pt_snapshot #(.W(SNAP_W), .SYNC(SYNC)) u_snap (
        .src_clk  (tmr_clk),
        .src_rst_n(t_rst_n),
        .src_value({run_q, cnt_q}),
        .dst_clk  (bus_clk),
        .dst_rst_n(b_rst_n),
        .dst_value(snap_b)
    );

    always_ff @(posedge bus_clk or negedge b_rst_n) begin
        if (!b_rst_n) begin
            auto_shadow_q <= 1'b0;
            load_shadow_q <= '0;
        end else begin
            if (ch_wr[CH_CTRL]) begin
                auto_shadow_q <= wdata[CTRL_AUTO];
            end
            if (ch_wr[CH_LOAD]) begin
                load_shadow_q <= wdata;
            end
        end
    end

    assign flag_set = ev_sync_q[SYNC-1] ^ ev_seen_q;
    assign flag_clr = wr_en && (addr == ADR_FLAG) && wdata[0];

    always_ff @(posedge bus_clk or negedge b_rst_n) begin
        if (!b_rst_n) begin
            ev_sync_q  <= '0;
            ev_seen_q  <= 1'b0;
            ovf_flag_q <= 1'b0;
        end else begin
            ev_sync_q <= {ev_sync_q[SYNC-2:0], ovf_tgl};
            ev_seen_q <= ev_sync_q[SYNC-1];
            if (flag_set) begin
                ovf_flag_q <= 1'b1;
            end else if (flag_clr) begin
                ovf_flag_q <= 1'b0;
            end
        end
    end

    assign ovf_irq = ovf_flag_q;

    always_ff @(posedge bus_clk or negedge b_rst_n) begin
        if (!b_rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (addr)
                ADR_CTRL:  rdata <= DW'({auto_shadow_q, snap_b[SNAP_W-1]});
                ADR_LOAD:  rdata <= load_shadow_q;
                ADR_COUNT: rdata <= snap_b[DW-1:0];
                ADR_PEND:  rdata <= DW'(pend_vec);
                ADR_FLAG:  rdata <= DW'(ovf_flag_q);
                default:   rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/posted_timer_sva.sv
module posted_timer_sva
    import pt_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          bus_clk,
    input logic          b_rst_n,
    input logic          tmr_clk,
    input logic          t_rst_n,
    input logic          wr_en,
    input logic [2:0]    addr,
    input logic [DW-1:0] wdata,
    input logic [2:0]    pend_vec,
    input logic          flag_set,
    input logic          ovf_irq,
    input logic [DW-1:0] cnt_q,
    input logic [DW-1:0] load_q,
    input logic          auto_q,
    input logic          run_q,
    input logic          ovf_evt,
    input logic [2:0]    ch_apply
);
    // R2: a register write is flagged pending on the next bus edge
    p_pend_after_write_r2: assert property (@(posedge bus_clk) disable iff (!b_rst_n)
        (wr_en && addr == ADR_COUNT) |=> pend_vec[CH_COUNT]);

    // R9: write-one clears the flag unless an overflow arrives together
    p_flag_clear_r9: assert property (@(posedge bus_clk) disable iff (!b_rst_n)
        (wr_en && addr == ADR_FLAG && wdata[0] && !flag_set) |=> !ovf_irq);

    // R9: the flag stays set unless explicitly cleared
    p_flag_sticky_r9: assert property (@(posedge bus_clk) disable iff (!b_rst_n)
        (ovf_irq && !(wr_en && addr == ADR_FLAG && wdata[0])) |=> ovf_irq);

    // R5: a running counter steps by one per tick below the top value
    p_step_r5: assert property (@(posedge tmr_clk) disable iff (!t_rst_n)
        (run_q && cnt_q != '1 && !ch_apply[CH_COUNT]) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R7: without auto-reload an overflow halts the counter
    p_halt_on_wrap_r7: assert property (@(posedge tmr_clk) disable iff (!t_rst_n)
        (ovf_evt && !auto_q && !ch_apply[CH_CTRL]) |=> !run_q);

    // R7 and R8: after a wrap the count is zero or the load value
    p_wrap_value_r8: assert property (@(posedge tmr_clk) disable iff (!t_rst_n)
        ovf_evt |=> cnt_q == ($past(auto_q) ? $past(load_q) : '0));

    // R4: a halted counter holds its value unless the count is written
    p_halt_hold_r4: assert property (@(posedge tmr_clk) disable iff (!t_rst_n)
        (!run_q && !ch_apply[CH_COUNT]) |=> $stable(cnt_q));
endmodule

bind posted_timer posted_timer_sva #(.DW(DW)) u_sva (
    .bus_clk (bus_clk),
    .b_rst_n (b_rst_n),
    .tmr_clk (tmr_clk),
    .t_rst_n (t_rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .pend_vec(pend_vec),
    .flag_set(flag_set),
    .ovf_irq (ovf_irq),
    .cnt_q   (cnt_q),
    .load_q  (load_q),
    .auto_q  (auto_q),
    .run_q   (run_q),
    .ovf_evt (ovf_evt),
    .ch_apply(ch_apply)
);

// File: tb/posted_timer_tb.sv
module posted_timer_tb;
    localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_CNT = 3'd2,
                           A_PEND = 3'd3, A_FLAG = 3'd4;
    localparam logic [31:0] TOP = 32'hFFFF_FFFF;

    logic        arst_n = 1'b0;
    logic        bus_clk = 1'b0, tmr_clk = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ovf_irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 bus_clk = ~bus_clk;
    always #7 tmr_clk = ~tmr_clk;

    posted_timer u_dut (
        .arst_n(arst_n), .bus_clk(bus_clk), .tmr_clk(tmr_clk),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input logic [31:0] act,
                           input logic [31:0] lo, input logic [31:0] hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h..%h", req, act, lo, hi);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        rd_en = 1'b1; addr = a;
        @(negedge bus_clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // R2: poll until the pending bit of channel ch is clear
    task automatic wait_idle(input int ch);
        logic [31:0] v;
        v = '1;
        for (int i = 0; i < 400; i++) begin
            bus_rd(A_PEND, v);
            if (!v[ch]) break;
        end
        chk("R2 pending clears", 32'(v[ch]), 32'd0);
    endtask

    task automatic safe_wr(input logic [2:0] a, input logic [31:0] d);
        wait_idle(int'(a));
        bus_wr(a, d);
    endtask

    task automatic settle();
        repeat (60) @(negedge bus_clk);
    endtask

    task automatic wait_irq(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge bus_clk);
            if (ovf_irq) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        #400us;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit          got;
        realtime     t0, t1;
        int          ticks;

        repeat (3) @(negedge bus_clk);
        arst_n = 1'b1;
        repeat (20) @(negedge bus_clk);

        // R1: reset state at every address
        for (int a = 0; a < 5; a++) begin
            bus_rd(3'(a), v);
            chk("R1 reset read", v, 32'd0);
        end
        chk("R1 irq low", 32'(ovf_irq), 32'd0);

        // R2: each channel reports pending right after a write
        for (int c = 0; c < 3; c++) begin
            bus_wr(3'(c), 32'd0);
            bus_rd(A_PEND, v);
            chk("R2 pending set", 32'(v[c]), 32'd1);
            wait_idle(c);
        end

        // R4: count write while halted, load untouched
        safe_wr(A_LOAD, 32'h0000_1234);
        safe_wr(A_CNT, 32'h0BAD_F00D);
        wait_idle(2);
        settle();
        bus_rd(A_CNT, v);
        chk("R4 count readback", v, 32'h0BAD_F00D);
        bus_rd(A_LOAD, v);
        chk("R4 load unchanged", v, 32'h0000_1234);

        // R3: three back-to-back count writes, the last one wins
        bus_wr(A_CNT, 32'h1111_1111);
        bus_wr(A_CNT, 32'h2222_2222);
        bus_wr(A_CNT, 32'h3333_3333);
        wait_idle(2);
        settle();
        bus_rd(A_CNT, v);
        chk("R3 newest count applied", v, 32'h3333_3333);

        // R5: elapsed ticks match elapsed timer time
        safe_wr(A_CNT, 32'd100);
        safe_wr(A_CTRL, 32'h1);
        t0 = $realtime;
        repeat (200) @(negedge bus_clk);
        safe_wr(A_CTRL, 32'h0);
        t1 = $realtime;
        wait_idle(0);
        settle();
        ticks = int'((t1 - t0) / 14.0);
        bus_rd(A_CNT, v);
        chk_rng("R5 one step per tick", v, 32'(100 + ticks - 3), 32'(100 + ticks + 3));

        // R6/R7: sweep of start values just below the top
        for (int n = 0; n < 12; n++) begin
            safe_wr(A_CNT, TOP - 32'(n));
            wait_idle(2);
            settle();
            bus_rd(A_CNT, v);
            chk("R4 preset before run", v, TOP - 32'(n));
            safe_wr(A_CTRL, 32'h1);
            wait_irq(got);
            chk("R6 overflow raises irq", 32'(got), 32'd1);
            settle();
            bus_rd(A_CNT, v);
            chk("R7 count zero after wrap", v, 32'd0);
            bus_rd(A_CTRL, v);
            chk("R7 start bit cleared", v, 32'd0);
            bus_rd(A_FLAG, v);
            chk("R6 flag set", v, 32'd1);
            bus_wr(A_FLAG, 32'h0);
            bus_rd(A_FLAG, v);
            chk("R9 zero write ignored", v, 32'd1);
            bus_wr(A_FLAG, 32'h1);
            bus_rd(A_FLAG, v);
            chk("R9 one write clears", v, 32'd0);
            chk("R9 irq cleared", 32'(ovf_irq), 32'd0);
        end

        // R6: no early overflow from a distant start value
        safe_wr(A_CNT, TOP - 32'd300);
        safe_wr(A_CTRL, 32'h1);
        repeat (100) @(negedge bus_clk);
        chk("R6 no early overflow", 32'(ovf_irq), 32'd0);
        safe_wr(A_CTRL, 32'h0);
        wait_idle(0);

        // R8: auto-reload from a properly posted load value
        safe_wr(A_LOAD, 32'd1000);
        safe_wr(A_CNT, TOP - 32'd2);
        safe_wr(A_CTRL, 32'h3);
        wait_irq(got);
        chk("R8 overflow with reload", 32'(got), 32'd1);
        bus_wr(A_CTRL, 32'h0);
        wait_idle(0);
        settle();
        bus_rd(A_CNT, v);
        chk_rng("R8 reloaded from load", v, 32'd1000, 32'd1030);
        bus_wr(A_FLAG, 32'h1);

        // R3: careless back-to-back load writes lose the earlier one
        wait_idle(1);
        bus_wr(A_LOAD, 32'h8000_0000);
        bus_wr(A_LOAD, 32'd0);
        safe_wr(A_CNT, TOP - 32'd1);
        safe_wr(A_CTRL, 32'h3);
        wait_irq(got);
        bus_wr(A_CTRL, 32'h0);
        wait_idle(0);
        settle();
        bus_rd(A_CNT, v);
        chk_rng("R3 earlier load lost", v, 32'd0, 32'd30);
        bus_rd(A_LOAD, v);
        chk("R3 load shows newest", v, 32'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule